// File: doc/BRIEF.md
# Delta Stream Constant Scaler

This block scales a one-bit delta-coded stream by a fixed binary fraction chosen at build time. A stream carries a value in [-1, 1] as the surplus of ones over zeros divided by the number of bits seen. A stream with as many ones as zeros stands for zero and is the neutral, or idle, stream.

The scaler is a chain of `COEF_W` adder cells. Each cell is a one-bit full adder whose outputs are used the other way round: the majority of the three inputs leaves as the stream bit, and the parity goes into a carry register. One such addition gives a stream worth half the sum of its two operands. The innermost cell adds either the input or the idle stream to the idle stream. Each outer cell adds either the input or the idle stream to the result of the cell inside it. The choice in each cell follows one coefficient bit. An internal toggle register produces the idle stream.

The product bit is combinational from the current input bit and the stored state, so it appears in the same clock cycle as the input bit. The usual user is a weighted synapse that feeds an adder tree of the same cells.

Top module: `dsm_coef_mult`

## Requirements
- R1: While `rst_ni` is low, every carry register and the idle toggle are cleared. With `x_i` = 0 in the first cycle after reset, `y_o` is 0.
- R2: The idle stream alternates 0,1,0,1,... and starts at 0 after reset. An input stream that alternates the same way, starting at 0, therefore gives a product whose ones-minus-zeros count stays within 3 of zero.
- R3: The coefficient is `COEF`, read as the fraction COEF / 2^COEF_W. Bit `COEF_W-1` has weight 1/2 and bit 0 has weight 2^-COEF_W. For any input stream that starts right after reset, at every prefix, the product count differs from COEF / 2^COEF_W times the input count (count = ones minus zeros) by at most 3.
- R4: An all-ones input (value +1) gives a product count within 3 of +COEF/2^COEF_W times the stream length.
- R5: An all-zeros input (value -1) gives a product count within 3 of -COEF/2^COEF_W times the stream length.
- R6: Each cell outputs the majority of its two operands and its stored carry. On the next clock it stores the XOR of those three bits. With `COEF_W` = 1 and `COEF` = 1, `y_o` equals maj(x, idle, carry) in every cycle.
- R7: `y_o` follows a change of `x_i` within the same cycle, with no clock edge in between, whenever the stream bit depends on it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock; one stream bit per rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| x_i | input | 1 | Input delta-coded stream bit |
| y_o | output | 1 | Product stream bit, combinational from `x_i` and state |

## Verification
The bench builds two copies. The first has `COEF_W` = 5 and `COEF` = 5'b10011, i.e. 19/32, with two zero bits between one bits. This makes an error in which coefficient bit goes to which stage show up in the scaled count. It is swept over all 65 densities of a 64-bit stream and over random and alternating streams. The second copy has a single cell with coefficient 1. It is small enough to follow exactly, bit by bit, against the majority and parity rule, and it shows the same-cycle path from input to output.

// File: rtl/dsm_pkg.sv
package dsm_pkg;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  function automatic logic par3(input logic a, input logic b, input logic c);
    return a ^ b ^ c;
  endfunction

endpackage

// File: rtl/dsm_idle_gen.sv
module dsm_idle_gen (
  input  logic clk_i,
  input  logic rst_ni,
  output logic idle_o
);
  logic tog_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) tog_q <= 1'b0;
    else         tog_q <= ~tog_q;
  end

  assign idle_o = tog_q;
endmodule

// File: rtl/dsm_delta_cell.sv
module dsm_delta_cell
  import dsm_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic a_i,
  input  logic b_i,
  output logic s_o,
  output logic c_o
);
  logic c_q;

  // majority leaves as the stream bit, parity is kept
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) c_q <= 1'b0;
    else         c_q <= par3(a_i, b_i, c_q);
  end

  assign s_o = maj3(a_i, b_i, c_q);
  assign c_o = c_q;
endmodule

// File: rtl/dsm_coef_mult.sv
module dsm_coef_mult #(
  parameter int unsigned        COEF_W = 5,
  parameter logic [COEF_W-1:0]  COEF   = 5'b10011
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic x_i,
  output logic y_o
);
  localparam int unsigned TOP = COEF_W - 1;

  logic              idle;
  logic [COEF_W-1:0] a_vec;
  logic [COEF_W-1:0] b_vec;
  logic [COEF_W-1:0] s_vec;
  logic [COEF_W-1:0] c_vec;

  dsm_idle_gen u_idle (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .idle_o(idle)
  );

  // stage 0 is innermost and takes coefficient bit 0 (weight 2^-COEF_W)
  for (genvar k = 0; k < COEF_W; k++) begin : g_stage
    if (COEF[k]) begin : g_take
      assign a_vec[k] = x_i;
    end else begin : g_skip
      assign a_vec[k] = idle;
    end

    if (k == 0) begin : g_inner
      assign b_vec[k] = idle;
    end else begin : g_outer
      assign b_vec[k] = s_vec[k-1];
    end

    dsm_delta_cell u_cell (
      .clk_i (clk_i),
      .rst_ni(rst_ni),
      .a_i   (a_vec[k]),
      .b_i   (b_vec[k]),
      .s_o   (s_vec[k]),
      .c_o   (c_vec[k])
    );
  end

  assign y_o = s_vec[TOP];
endmodule

// File: rtl/dsm_coef_mult_chk.sv
module dsm_coef_mult_chk #(
  parameter int unsigned        COEF_W = 5,
  parameter logic [COEF_W-1:0]  COEF   = 5'b10011
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              x_i,
  input logic              y_o,
  input logic              idle,
  input logic [COEF_W-1:0] a_vec,
  input logic [COEF_W-1:0] b_vec,
  input logic [COEF_W-1:0] s_vec,
  input logic [COEF_W-1:0] c_vec
);
  localparam longint SCALE = longint'(1) <<< COEF_W;
  localparam longint CVAL  = longint'(COEF);
  localparam longint TOL   = 3 * SCALE;

  logic   live_q;
  longint d_in_q, d_out_q, err;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      live_q  <= 1'b0;
      d_in_q  <= 0;
      d_out_q <= 0;
    end else begin
      live_q  <= 1'b1;
      d_in_q  <= d_in_q  + (x_i ? 64'sd1 : -64'sd1);
      d_out_q <= d_out_q + (y_o ? 64'sd1 : -64'sd1);
    end
  end

  always_comb err = d_out_q * SCALE - CVAL * d_in_q;

  // R1
  a_r1_reset_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (c_vec == '0 && idle == 1'b0));

  // R2
  a_r2_idle_toggle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    live_q |-> (idle != $past(idle)));

  // R3
  a_r3_scaled_track: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (err <= TOL) && (err >= -TOL));

  // R6: 2*stream + new carry equals the bit sum of the cycle before
  for (genvar k = 0; k < COEF_W; k++) begin : g_cell_chk
    a_r6_cell_balance: assert property (@(posedge clk_i) disable iff (!rst_ni)
      live_q |-> ({1'b0, $past(a_vec[k])} + {1'b0, $past(b_vec[k])} + {1'b0, $past(c_vec[k])})
                 == {$past(s_vec[k]), c_vec[k]});
  end
endmodule

bind dsm_coef_mult dsm_coef_mult_chk #(.COEF_W(COEF_W), .COEF(COEF)) u_chk (
  .clk_i (clk_i),
  .rst_ni(rst_ni),
  .x_i   (x_i),
  .y_o   (y_o),
  .idle  (idle),
  .a_vec (a_vec),
  .b_vec (b_vec),
  .s_vec (s_vec),
  .c_vec (c_vec)
);

// File: tb/dsm_coef_mult_bench.sv
module dsm_coef_mult_bench;
  localparam int CLK_P = 10;
  localparam int W5    = 5;
  localparam logic [W5-1:0] C5 = 5'b10011;
  localparam longint SC5 = 32;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic x5 = 1'b0, x1 = 1'b0;
  logic y5, y1;
  int total = 0, bad = 0;

  always #(CLK_P/2) clk = ~clk;

  dsm_coef_mult #(.COEF_W(W5), .COEF(C5)) u_dsm_coef_mult (
    .clk_i(clk), .rst_ni(rst_n), .x_i(x5), .y_o(y5));

  dsm_coef_mult #(.COEF_W(1), .COEF(1'b1)) u_dsm_coef_mult_one (
    .clk_i(clk), .rst_ni(rst_n), .x_i(x1), .y_o(y1));

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; x5 = 1'b0; x1 = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  // mode 0: evenly spread k ones, 1: random, 2: alternating from 0
  task automatic run5(input int len, input int mode, input int k, input string req);
    longint din = 0, dout = 0, err, exp;
    do_reset();
    for (int i = 0; i < len; i++) begin
      logic b;
      case (mode)
        0:       b = (((i + 1) * k) / len) != ((i * k) / len);
        1:       b = logic'($urandom_range(0, 1));
        default: b = logic'(i % 2);
      endcase
      x5 = b;
      #1;
      din  += b  ? 1 : -1;
      dout += y5 ? 1 : -1;
      @(negedge clk);
    end
    err = dout * SC5 - longint'(C5) * din;
    exp = (longint'(C5) * din) / SC5;
    check(err <= 3 * SC5 && err >= -3 * SC5, req, dout, exp);
  endtask

  initial begin
    #(CLK_P * 150000);
    check(1'b0, "watchdog", 0, 1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    // R1: state cleared, zero input gives zero product in first cycle
    do_reset();
    #1;
    check(y5 == 1'b0, "R1 y5", longint'(y5), 0);
    check(y1 == 1'b0, "R1 y1", longint'(y1), 0);

    // R5 / R4 at the ends, R3 across every density of a 64-bit stream
    run5(64, 0, 0,  "R5 all zeros");
    run5(64, 0, 64, "R4 all ones");
    run5(256, 0, 0,   "R5 all zeros long");
    run5(256, 0, 256, "R4 all ones long");
    for (int k = 1; k < 64; k++) run5(64, 0, k, "R3 density sweep");
    for (int n = 0; n < 24; n++) run5(256, 1, 0, "R3 random");
    // R2: idle-like input
    run5(64, 2, 0, "R2 alternating");
    run5(201, 2, 0, "R2 alternating odd");

    // R6 / R7: single cell followed exactly
    begin
      logic m_idle = 1'b0, m_c = 1'b0;
      do_reset();
      for (int i = 0; i < 400; i++) begin
        logic b, e;
        b = logic'($urandom_range(0, 1));
        if (m_idle != m_c) begin
          x1 = 1'b0; #1;
          check(y1 == 1'b0, "R7 low", longint'(y1), 0);
          x1 = 1'b1; #1;
          check(y1 == 1'b1, "R7 high", longint'(y1), 1);
        end
        x1 = b; #1;
        e = (b & m_idle) | (b & m_c) | (m_idle & m_c);
        check(y1 == e, "R6 cell", longint'(y1), longint'(e));
        m_c    = b ^ m_idle ^ m_c;
        m_idle = ~m_idle;
        @(negedge clk);
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule